// File: doc/BRIEF.md
# Low-Power Lane Turnaround Controller

This block hands ownership of a bidirectional data lane back and forth while the lane is in low-power signalling. It works in both roles. As the current owner, a request makes it drive the turnaround pattern and then the bridge state (both wires low), after which it lets go of the lane. As the listener, it watches the two wire levels for the same pattern, waits a programmable settling interval inside the bridge, drives the bridge itself, announces itself with one request state and then parks the lane in the stop state as the new owner.

Every hold time is a multiple of a single programmable unit, `lpx_cycles`, counted in clock cycles. A second input lengthens the listener's settling wait beyond one unit, clamped at two units. The block checks every line state it sees against what it expects. While it drives, the lane must read back what it drives. While it listens, the lane must follow the turnaround pattern. Any mismatch sends it to an error state that lets go of the lane. It leaves that state once the lane has rested in the stop state for one unit.

Line states are given as a two-bit value {P, N}: stop = 2'b11, request = 2'b10, bridge = 2'b00, and 2'b01 is the remaining state.

Top module: `lp_turnaround_ctrl`

## Requirements
- R1: After reset the block owns the lane (`owner`=1), drives it (`drive_en`=1) with the stop state 2'b11, and `done` and `err` are 0.
- R2: When `ta_req` is high in a clock cycle where the block owns the lane and is idle, it drives 2'b10, 2'b00 and 2'b10 for one unit each, and then 2'b00 for four units. `drive_en` stays 1 throughout.
- R3: In the cycle after the four-unit bridge ends, `drive_en` is 0, `owner` is 0 and `done` is 1. `done` is high for exactly one cycle. `owner` changes only in a cycle where `done` is high.
- R4: `ta_req` has no effect while the block does not own the lane. It also has no effect while a sequence is running, so holding it high does not change that sequence.
- R5: While listening, the block follows the lane through 2'b10, 2'b00, 2'b10 and then 2'b00. It keeps `drive_en` at 0 for a settling wait of S cycles counted from the first bridge sample, where S = `lpx` + min(`sure_ext`, `lpx`). After that it starts driving 2'b00.
- R6: The block then drives 2'b00 for five units and 2'b10 for one unit. In the next cycle it drives 2'b11 with `owner`=1 and `done`=1.
- R7: While `drive_en` is 1, a lane state that differs from `line_out` sends the block to the error state. In the next cycle `err` is 1 and `drive_en` is 0.
- R8: While listening, 2'b01 during the pattern, or any state other than 2'b00 during the settling wait, causes an error. A return to 2'b11 right after the first 2'b10 is not an error, and the block returns to listening.
- R9: `err` stays 1 until the lane has read 2'b11 for `lpx` consecutive cycles. The block then returns to idle with `owner` unchanged, driving the lane again only if it owns it.
- R10: An `lpx_cycles` value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lpx_cycles | input | CNT_W | Length of one unit in clock cycles |
| sure_ext | input | CNT_W | Extra cycles added to the listener's settling wait (clamped to one unit) |
| ta_req | input | 1 | Request to hand the lane over |
| line_in | input | 2 | Observed lane state {P, N} |
| line_out | output | 2 | State driven onto the lane {P, N} |
| drive_en | output | 1 | Driver enable for the lane |
| owner | output | 1 | 1 while this side owns the lane |
| done | output | 1 | One-cycle pulse when ownership changes |
| err | output | 1 | High while in the error state |

## Verification
A wrong state in the sequencer shows up on `line_out` within one unit, because every phase drives a distinct value or lasts a distinct length. A wrong counter load changes the length of a phase, and the bench catches this by checking every cycle. A wrong decision in the listener shows as `drive_en` rising too early or too late against the settling window, or as `err` being missed or raised wrongly. An ownership slip shows on `owner` and `done` at the end of each handover.

// File: rtl/lp_turnaround_ctrl.sv
module lp_turnaround_ctrl #(
  parameter int CNT_W          = 12,
  parameter bit OWNER_AT_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lpx_cycles,
  input  logic [CNT_W-1:0] sure_ext,
  input  logic             ta_req,
  input  logic [1:0]       line_in,
  output logic [1:0]       line_out,
  output logic             drive_en,
  output logic             owner,
  output logic             done,
  output logic             err
);
  localparam int LW = CNT_W + 3;
  localparam logic [1:0] LS_STOP = 2'b11, LS_REQ = 2'b10, LS_BRG = 2'b00;

  typedef enum logic [3:0] {
    S_IDLE, S_GIVE_RQ, S_GIVE_BR, S_GIVE_RQ2, S_GIVE_GO,
    S_TAKE_RQ, S_TAKE_BR, S_TAKE_RQ2, S_TAKE_WAIT, S_TAKE_GET, S_TAKE_ANN,
    S_FAULT
  } st_t;

  st_t st, st_nx;
  logic [LW-1:0] cnt, cnt_ld;
  logic          ld, flip, own_r, done_r;

  wire [CNT_W-1:0] unit   = (lpx_cycles == '0) ? CNT_W'(1) : lpx_cycles;
  wire [CNT_W-1:0] extra  = (sure_ext > unit) ? unit : sure_ext;
  wire [LW-1:0]    unit_w = LW'(unit);
  wire [LW-1:0]    len1   = unit_w - LW'(1);
  wire [LW-1:0]    len4   = (unit_w << 2) - LW'(1);
  wire [LW-1:0]    len5   = (unit_w << 2) + unit_w - LW'(1);
  wire [LW-1:0]    lenw   = unit_w + LW'(extra) - LW'(1);
  wire             tick   = (cnt == '0);

  always_comb begin
    unique case (st)
      S_IDLE:                  drive_en = own_r;
      S_GIVE_RQ, S_GIVE_BR,
      S_GIVE_RQ2, S_GIVE_GO,
      S_TAKE_GET, S_TAKE_ANN:  drive_en = 1'b1;
      default:                 drive_en = 1'b0;
    endcase
    unique case (st)
      S_GIVE_RQ, S_GIVE_RQ2, S_TAKE_ANN: line_out = LS_REQ;
      S_GIVE_BR, S_GIVE_GO, S_TAKE_GET:  line_out = LS_BRG;
      default:                           line_out = LS_STOP;
    endcase
  end

  wire clash = drive_en && (line_in != line_out);

  always_comb begin
    st_nx  = st;
    ld     = 1'b0;
    cnt_ld = len1;
    flip   = 1'b0;
    if (clash) begin
      st_nx = S_FAULT;
      ld    = 1'b1;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (own_r) begin
            if (ta_req) begin st_nx = S_GIVE_RQ; ld = 1'b1; end
          end else if (line_in == LS_REQ) begin
            st_nx = S_TAKE_RQ;
          end
        end
        S_GIVE_RQ:  if (tick) begin st_nx = S_GIVE_BR;  ld = 1'b1; end
        S_GIVE_BR:  if (tick) begin st_nx = S_GIVE_RQ2; ld = 1'b1; end
        S_GIVE_RQ2: if (tick) begin st_nx = S_GIVE_GO;  ld = 1'b1; cnt_ld = len4; end
        S_GIVE_GO:  if (tick) begin st_nx = S_IDLE; flip = 1'b1; end
        S_TAKE_RQ: begin
          unique case (line_in)
            LS_REQ:  st_nx = S_TAKE_RQ;
            LS_BRG:  st_nx = S_TAKE_BR;
            LS_STOP: st_nx = S_IDLE;
            default: begin st_nx = S_FAULT; ld = 1'b1; end
          endcase
        end
        S_TAKE_BR: begin
          if (line_in == LS_REQ) st_nx = S_TAKE_RQ2;
          else if (line_in != LS_BRG) begin st_nx = S_FAULT; ld = 1'b1; end
        end
        S_TAKE_RQ2: begin
          if (line_in == LS_BRG) begin st_nx = S_TAKE_WAIT; ld = 1'b1; cnt_ld = lenw; end
          else if (line_in != LS_REQ) begin st_nx = S_FAULT; ld = 1'b1; end
        end
        S_TAKE_WAIT: begin
          if (line_in != LS_BRG) begin st_nx = S_FAULT; ld = 1'b1; end
          else if (tick) begin st_nx = S_TAKE_GET; ld = 1'b1; cnt_ld = len5; end
        end
        S_TAKE_GET: if (tick) begin st_nx = S_TAKE_ANN; ld = 1'b1; end
        S_TAKE_ANN: if (tick) begin st_nx = S_IDLE; flip = 1'b1; end
        S_FAULT: begin
          if (line_in != LS_STOP) ld = 1'b1;
          else if (tick) st_nx = S_IDLE;
        end
        default: begin st_nx = S_FAULT; ld = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      own_r  <= OWNER_AT_RESET;
      done_r <= 1'b0;
    end else begin
      st     <= st_nx;
      cnt    <= ld ? cnt_ld : (tick ? cnt : cnt - LW'(1));
      own_r  <= own_r ^ flip;
      done_r <= flip;
    end
  end

  assign owner = own_r;
  assign done  = done_r;
  assign err   = (st == S_FAULT);
endmodule

// File: rtl/lp_turnaround_chk.sv
module lp_turnaround_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ta_req,
  input logic [1:0] line_in,
  input logic [1:0] line_out,
  input logic       drive_en,
  input logic       owner,
  input logic       done,
  input logic       err
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                   // R3
  AST_OWNER_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != $past(owner)) |-> done);                                 // R3
  AST_RELEASE_ON_GIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !owner) |-> !drive_en);                                   // R3
  AST_TAKE_PARKS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && owner) |-> (drive_en && line_out == 2'b11));              // R6
  AST_TAKE_STARTS_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drive_en) && !owner) |-> (line_out == 2'b00));              // R5
  AST_FAULT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !drive_en);                                                // R7
  AST_FAULT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done);                                                    // R9
endmodule

bind lp_turnaround_ctrl lp_turnaround_chk u_chk (.*);

// File: tb/sim_lp_turnaround_ctrl.sv
module sim_lp_turnaround_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ta_req = 1'b0;
  logic [11:0] lpx = 12'd4;
  logic [11:0] ext = 12'd0;
  logic        rem_drv = 1'b0;
  logic [1:0]  rem_val = 2'b11;
  logic        contend = 1'b0;
  logic [1:0]  lane, line_out;
  logic        drive_en, owner, done, err;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  always_comb lane = drive_en ? (contend ? 2'b01 : line_out) : (rem_drv ? rem_val : 2'b11);

  lp_turnaround_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .lpx_cycles(lpx), .sure_ext(ext), .ta_req(ta_req),
    .line_in(lane), .line_out(line_out), .drive_en(drive_en), .owner(owner),
    .done(done), .err(err));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) nx();
    rst_n = 1'b1;
    nx();
    chk("R1 drive_en", drive_en, 1);
    chk("R1 owner", owner, 1);
    chk("R1 line_out", line_out, 3);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_give(input int l, input bit hold);
    int e;
    e = (l == 0) ? 1 : l;
    lpx = 12'(l);
    ta_req = 1'b1;
    for (int n = 1; n <= 7*e + 2; n++) begin
      nx();
      if (!hold) ta_req = 1'b0;
      if (n <= 7*e) begin
        chk("R2 drive_en", drive_en, 1);
        if (n <= e)           chk(l == 0 ? "R10 line_out" : "R2 line_out", line_out, 2);
        else if (n <= 2*e)    chk("R2 line_out", line_out, 0);
        else if (n <= 3*e)    chk(l == 0 ? "R10 line_out" : "R2 line_out", line_out, 2);
        else                  chk(hold ? "R4 line_out" : "R2 line_out", line_out, 0);
      end else if (n == 7*e + 1) begin
        chk("R3 drive_en", drive_en, 0);
        chk("R3 owner", owner, 0);
        chk("R3 done", done, 1);
      end else begin
        chk("R3 done low", done, 0);
        chk("R4 drive_en", drive_en, 0);
      end
    end
    ta_req = 1'b0;
  endtask

  task automatic t_ignore();
    ta_req = 1'b1;
    for (int n = 1; n <= 6; n++) begin
      nx();
      chk("R4 drive_en", drive_en, 0);
      chk("R4 owner", owner, 0);
    end
    ta_req = 1'b0;
  endtask

  task automatic t_take(input int l, input int x, input int s);
    lpx = 12'(l);
    ext = 12'(x);
    for (int n = 0; n <= 9*l + s + 2; n++) begin
      if (n > 0) nx();
      rem_drv = (n < 7*l);
      if (n < l)            rem_val = 2'b10;
      else if (n < 2*l)     rem_val = 2'b00;
      else if (n < 3*l)     rem_val = 2'b10;
      else                  rem_val = 2'b00;
      if (n > 0) begin
        if (n <= 3*l + s) chk("R5 wait drive_en", drive_en, 0);
        else if (n <= 8*l + s) begin
          chk("R6 get drive_en", drive_en, 1);
          chk("R6 get line_out", line_out, 0);
        end else if (n <= 9*l + s) begin
          chk("R6 announce line_out", line_out, 2);
        end else if (n == 9*l + s + 1) begin
          chk("R6 stop line_out", line_out, 3);
          chk("R6 owner", owner, 1);
          chk("R6 done", done, 1);
        end else begin
          chk("R6 done low", done, 0);
          chk("R6 err", err, 0);
        end
      end
    end
    rem_drv = 1'b0;
  endtask

  task automatic t_contend(input int l);
    lpx = 12'(l);
    ta_req = 1'b1;
    nx();
    ta_req = 1'b0;
    contend = 1'b1;
    nx();
    chk("R7 err", err, 1);
    chk("R7 drive_en", drive_en, 0);
    contend = 1'b0;
    for (int n = 3; n <= l + 2; n++) begin
      nx();
      if (n <= l + 1) chk("R9 err held", err, 1);
      else begin
        chk("R9 err cleared", err, 0);
        chk("R9 owner kept", owner, 1);
        chk("R9 drive_en", drive_en, 1);
        chk("R9 line_out", line_out, 3);
      end
    end
  endtask

  task automatic t_abort(input int l);
    lpx = 12'(l);
    rem_drv = 1'b1;
    rem_val = 2'b10;
    repeat (l) nx();
    rem_drv = 1'b0;
    for (int n = 1; n <= 2*l; n++) begin
      nx();
      chk("R8 abort err", err, 0);
      chk("R8 abort drive_en", drive_en, 0);
    end
  endtask

  task automatic t_bad_pattern(input int l);
    lpx = 12'(l);
    rem_drv = 1'b1;
    for (int n = 0; n <= 3*l + 1; n++) begin
      if (n > 0) nx();
      if (n < l)          rem_val = 2'b10;
      else if (n < 2*l)   rem_val = 2'b00;
      else if (n == 2*l)  rem_val = 2'b01;
      else                rem_drv = 1'b0;
      if (n == 2*l + 1) begin
        chk("R8 pattern err", err, 1);
        chk("R8 pattern drive_en", drive_en, 0);
      end else if (n > 2*l + 1 && n <= 3*l) begin
        chk("R9 err held", err, 1);
      end else if (n == 3*l + 1) begin
        chk("R9 err cleared", err, 0);
        chk("R9 owner kept", owner, 0);
        chk("R9 drive_en", drive_en, 0);
      end else if (n > 0) begin
        chk("R8 pre err", err, 0);
      end
    end
    rem_drv = 1'b0;
  endtask

  task automatic t_wait_break(input int l);
    lpx = 12'(l);
    ext = 12'd0;
    rem_drv = 1'b1;
    for (int n = 0; n <= 3*l + 2; n++) begin
      if (n > 0) nx();
      if (n < l)          rem_val = 2'b10;
      else if (n < 2*l)   rem_val = 2'b00;
      else if (n < 3*l)   rem_val = 2'b10;
      else if (n == 3*l)  rem_val = 2'b00;
      else                rem_drv = 1'b0;
      if (n == 3*l + 2) chk("R8 wait err", err, 1);
      else if (n > 0)   chk("R8 wait pre err", err, 0);
    end
    repeat (l) nx();
    chk("R9 err cleared", err, 0);
    chk("R9 owner kept", owner, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_give(4, 1'b0);
    t_ignore();
    t_take(4, 0, 4);
    t_give(3, 1'b1);
    t_take(3, 100, 6);
    t_contend(4);
    t_give(0, 1'b0);
    t_abort(4);
    t_take(5, 2, 7);
    t_give(4, 1'b0);
    t_bad_pattern(4);
    t_wait_break(4);
    t_take(1, 1, 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule